// File: doc/BRIEF.md
# Counted Transition Output Generator

This block drives one output line through a programmed number of level changes. Every change lands on the boundary of a base period. The length of that period comes from the low half of a 32-bit configuration word. A separate 32-bit count write gives the number of changes to make. The period timer starts when the enable input rises. It then runs on without stopping, so every level change stays in phase with that start, whenever the count is written.

Once the last requested change has happened, a completion flag rises in the same clock edge. The output then holds whatever level it reached. Software can therefore load the next count during the quiet period that follows. Writing a new nonzero count clears the flag, and so does an acknowledge strobe. While the enable input is low, the block is held cleared: the output is low, the flag is low, no changes are pending, and the period timer waits at its start phase.

Top module: `ctg_transition_gen`

## Requirements
- R1: While enabled, period boundaries repeat every P clock cycles. P is the value of `period_word_i[15:0]`, and the output changes level only on a boundary.
- R2: A value of 0 in `period_word_i[15:0]` gives a period of one cycle. Bits 31:16 of `period_word_i` have no effect.
- R3: The period timer starts when enable rises and runs whether or not changes are pending. Counting the first enabled cycle as cycle 0, boundaries fall in cycles kP-1 (k = 1, 2, ...), no matter when counts are written.
- R4: A one-cycle write of a nonzero count N makes exactly N level changes, one on each boundary. The first change is on the first boundary after the write cycle; a boundary in the write cycle itself produces no change.
- R5: The completion flag `done_o` rises on the same clock edge as the last level change. After that, the output keeps its final level (which may be high) until a new count is written or the block is disabled.
- R6: `done_o` is cleared by a one-cycle `ack_i` pulse, and also by a write of a nonzero count. If the last change and an acknowledge happen in the same cycle, the flag is set.
- R7: A count write with value 0 is ignored. The output, the flag and the pending changes stay as they were.
- R8: While `en_i` is low, and during `rst_ni` low, `pin_o` and `done_o` are 0, pending changes are dropped, and count writes are ignored. When enable rises again, the period phase restarts from cycle 0.
- R9: A nonzero count written while changes are still pending replaces the remaining count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Enable; low holds the block cleared |
| period_word_i | input | 32 | Configuration word; bits 15:0 are the base period in cycles |
| count_wr_i | input | 1 | One-cycle strobe that writes `count_i` |
| count_i | input | 32 | Number of level changes to make |
| ack_i | input | 1 | One-cycle strobe that clears the completion flag |
| pin_o | output | 1 | Generated output level |
| done_o | output | 1 | Completion flag |

## Verification
A period timer that ran in the wrong phase would show as a level change one or more cycles away from the cycle kP-1 that R3 predicts, already on the first change after a write. A remaining count that is off by one shows up one period after the expected end. Either `pin_o` makes one change too many or too few, or `done_o` rises one boundary early or late. A flag or output that is not cleared properly shows on the first edge after enable falls. A write that wrongly counts its own boundary moves the first change one period earlier.

// File: rtl/ctg_pkg.sv
package ctg_pkg;
  // What the transition controller does in a given cycle
  typedef enum logic [1:0] {
    CTG_ACT_IDLE   = 2'd0,
    CTG_ACT_LOAD   = 2'd1,
    CTG_ACT_TOGGLE = 2'd2,
    CTG_ACT_CLEAR  = 2'd3
  } ctg_act_e;
endpackage

// File: rtl/ctg_period_timer.sv
module ctg_period_timer #(
  parameter int PERIOD_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic [PERIOD_W-1:0] period_i,
  output logic                tick_o
);
  // The effective period: a zero field is taken as a single cycle
  function automatic logic [PERIOD_W-1:0] eff_period(input logic [PERIOD_W-1:0] raw);
    return (raw == '0) ? PERIOD_W'(1) : raw;
  endfunction

  logic [PERIOD_W-1:0] elapsed_q;
  logic [PERIOD_W-1:0] last_phase;

  assign last_phase = eff_period(period_i) - PERIOD_W'(1);
  // '>=' keeps the timer bounded if the period is made shorter mid-run
  assign tick_o     = en_i && (elapsed_q >= last_phase);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
    end else if (!en_i) begin
      elapsed_q <= '0;
    end else if (tick_o) begin
      elapsed_q <= '0;
    end else begin
      elapsed_q <= elapsed_q + PERIOD_W'(1);
    end
  end

  AST_PHASE_ZERO_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (elapsed_q == '0)); // R8

  AST_PHASE_BELOW_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $stable(period_i)) |=> (elapsed_q < eff_period(period_i))); // R1
endmodule

// File: rtl/ctg_done_flag.sv
module ctg_done_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic set_i,
  input  logic ack_i,
  input  logic load_i,
  output logic done_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
    end else if (!en_i) begin
      done_o <= 1'b0;
    end else if (set_i) begin
      done_o <= 1'b1;
    end else if (ack_i || load_i) begin
      done_o <= 1'b0;
    end
  end

  AST_DONE_ON_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && set_i) |=> done_o); // R5

  AST_DONE_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !set_i && (ack_i || load_i)) |=> !done_o); // R6

  AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && done_o && !ack_i && !load_i) |=> done_o); // R5
endmodule

// File: rtl/ctg_transition_ctrl.sv
module ctg_transition_ctrl
  import ctg_pkg::*;
#(
  parameter int COUNT_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               wr_i,
  input  logic [COUNT_W-1:0] count_i,
  output logic               pin_o,
  output logic               load_o,
  output logic               last_o
);
  ctg_act_e           act;
  logic [COUNT_W-1:0] remain_q;
  logic               wr_nonzero;

  assign wr_nonzero = wr_i && (count_i != '0);

  // A write takes priority over a boundary in the same cycle, so that
  // boundary is not spent on the new count
  always_comb begin
    if (!en_i)                           act = CTG_ACT_CLEAR;
    else if (wr_nonzero)                 act = CTG_ACT_LOAD;
    else if (tick_i && remain_q != '0)   act = CTG_ACT_TOGGLE;
    else                                 act = CTG_ACT_IDLE;
  end

  assign load_o = (act == CTG_ACT_LOAD);
  assign last_o = (act == CTG_ACT_TOGGLE) && (remain_q == COUNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      remain_q <= '0;
      pin_o    <= 1'b0;
    end else begin
      unique case (act)
        CTG_ACT_CLEAR: begin
          remain_q <= '0;
          pin_o    <= 1'b0;
        end
        CTG_ACT_LOAD: remain_q <= count_i;
        CTG_ACT_TOGGLE: begin
          remain_q <= remain_q - COUNT_W'(1);
          pin_o    <= ~pin_o;
        end
        default: ;
      endcase
    end
  end

  AST_CHANGE_ONLY_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(pin_o)); // R1

  AST_WRITE_CYCLE_NO_CHANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && wr_nonzero) |=> $stable(pin_o)); // R4

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && remain_q == '0 && !wr_nonzero) |=> ($stable(pin_o) && remain_q == '0)); // R5

  AST_CLEARED_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pin_o && remain_q == '0)); // R8
endmodule

// File: rtl/ctg_transition_gen.sv
module ctg_transition_gen #(
  parameter int WORD_W   = 32,
  parameter int PERIOD_W = 16,
  parameter int COUNT_W  = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [WORD_W-1:0]  period_word_i,
  input  logic               count_wr_i,
  input  logic [COUNT_W-1:0] count_i,
  input  logic               ack_i,
  output logic               pin_o,
  output logic               done_o
);
  localparam int UPPER_W = WORD_W - PERIOD_W;

  logic                boundary_tick;
  logic                count_loaded;
  logic                last_change;
  logic [PERIOD_W-1:0] period_field;
  logic [UPPER_W-1:0]  unused_upper;

  assign period_field = period_word_i[PERIOD_W-1:0];
  assign unused_upper = period_word_i[WORD_W-1:PERIOD_W];

  ctg_period_timer #(.PERIOD_W(PERIOD_W)) timer_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .period_i(period_field),
    .tick_o  (boundary_tick)
  );

  ctg_transition_ctrl #(.COUNT_W(COUNT_W)) ctrl_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .tick_i (boundary_tick),
    .wr_i   (count_wr_i),
    .count_i(count_i),
    .pin_o  (pin_o),
    .load_o (count_loaded),
    .last_o (last_change)
  );

  ctg_done_flag done_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .set_i (last_change),
    .ack_i (ack_i),
    .load_i(count_loaded),
    .done_o(done_o)
  );

  AST_LOAD_AND_LAST_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(count_loaded && last_change)); // R6

  AST_OUTPUTS_LOW_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!pin_o && !done_o)); // R8
endmodule

// File: tb/ctg_transition_gen_tb.sv
module ctg_transition_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic [31:0] period_word = 32'd5;
  logic        wr = 1'b0;
  logic [31:0] cnt = 32'd0;
  logic        ack = 1'b0;
  logic        pin;
  logic        done;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  always #4 clk = ~clk;

  ctg_transition_gen dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en), .period_word_i(period_word),
    .count_wr_i(wr), .count_i(cnt), .ack_i(ack), .pin_o(pin), .done_o(done)
  );

  // After each step the bench sits at a falling edge. cyc is the cycle now
  // starting, so edge k (the edge that ends cycle k) has just been seen at cyc == k+1.
  task automatic step();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic goto_cyc(input int c);
    while (cyc < c) step();
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s cyc=%0d actual=%b expected=%b", req, what, cyc, act, exp);
    end
  endtask

  task automatic pulse_wr(input logic [31:0] v);
    wr = 1'b1; cnt = v;
    step();
    wr = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    step();
    ack = 1'b0;
  endtask

  task automatic test_reset();
    chk("R8", "pin in reset", pin, 1'b0);
    chk("R8", "done in reset", done, 1'b0);
  endtask

  // P=5: boundaries in cycles 4,9,14,...
  task automatic test_basic_run();
    en = 1'b1; cyc = 0;
    step();                       // cycle 1
    pulse_wr(32'd3);              // write in cycle 1
    goto_cyc(4);  chk("R4", "no change before first boundary", pin, 1'b0);
    goto_cyc(5);  chk("R3", "first change at cycle 4", pin, 1'b1);
    goto_cyc(9);  chk("R1", "stable inside period", pin, 1'b1);
    goto_cyc(10); chk("R1", "second change at cycle 9", pin, 1'b0);
    chk("R5", "done not early", done, 1'b0);
    goto_cyc(14); chk("R5", "done not before last", done, 1'b0);
    goto_cyc(15); chk("R4", "third change", pin, 1'b1);
    chk("R5", "done with last change", done, 1'b1);
    goto_cyc(25); chk("R5", "level held high", pin, 1'b1);
    chk("R4", "no extra change", done, 1'b1);
  endtask

  task automatic test_zero_write();
    goto_cyc(25);
    pulse_wr(32'd0);
    goto_cyc(30);
    chk("R7", "zero write leaves pin", pin, 1'b1);
    chk("R7", "zero write leaves done", done, 1'b1);
  endtask

  // Write in boundary cycle 34: changes at 39 and 44
  task automatic test_write_on_boundary();
    goto_cyc(34);
    pulse_wr(32'd2);
    chk("R6", "nonzero write clears done", done, 1'b0);
    chk("R4", "write-cycle boundary unused", pin, 1'b1);
    goto_cyc(40); chk("R4", "first change after write", pin, 1'b0);
    chk("R5", "done waits", done, 1'b0);
    goto_cyc(45); chk("R4", "second change", pin, 1'b1);
    chk("R5", "done after two", done, 1'b1);
    pulse_ack();
    chk("R6", "ack clears done", done, 1'b0);
    chk("R6", "ack leaves pin", pin, 1'b1);
  endtask

  task automatic test_replace();
    goto_cyc(46);
    pulse_wr(32'd4);
    goto_cyc(50); chk("R9", "change from count 4", pin, 1'b0);
    pulse_wr(32'd1);
    goto_cyc(55); chk("R9", "replaced count change", pin, 1'b1);
    chk("R9", "done after replaced count", done, 1'b1);
    goto_cyc(60); chk("R9", "no further change", pin, 1'b1);
  endtask

  task automatic test_disable();
    goto_cyc(60);
    en = 1'b0;
    step();
    chk("R8", "pin low when off", pin, 1'b0);
    chk("R8", "done low when off", done, 1'b0);
    pulse_wr(32'd5);
    step(); step();
    chk("R8", "write ignored when off", pin, 1'b0);
  endtask

  // P=3 with junk in the upper half; phase restarts: boundaries 2,5
  task automatic test_reenable();
    period_word = 32'h0007_0003;
    en = 1'b1; cyc = 0;
    pulse_wr(32'd2);
    chk("R8", "no change at cycle 0", pin, 1'b0);
    goto_cyc(3); chk("R8", "phase restarted, change at 2", pin, 1'b1);
    chk("R2", "upper bits ignored", done, 1'b0);
    goto_cyc(5); chk("R2", "held between boundaries", pin, 1'b1);
    goto_cyc(6); chk("R2", "change at 5", pin, 1'b0);
    chk("R5", "done ends low level", done, 1'b1);
    step(); step();
    chk("R5", "low level held", pin, 1'b0);
  endtask

  // Period field 0 acts as one cycle; write-cycle boundary 0 is skipped
  task automatic test_zero_period();
    en = 1'b0; step();
    period_word = 32'h1234_0000;
    en = 1'b1; cyc = 0;
    pulse_wr(32'd3);
    chk("R2", "write cycle skipped", pin, 1'b0);
    goto_cyc(2); chk("R2", "change every cycle a", pin, 1'b1);
    goto_cyc(3); chk("R2", "change every cycle b", pin, 1'b0);
    chk("R2", "done not yet", done, 1'b0);
    goto_cyc(4); chk("R2", "change every cycle c", pin, 1'b1);
    chk("R2", "done after three", done, 1'b1);
    goto_cyc(5); chk("R4", "exactly three changes", pin, 1'b1);
    ack = 1'b1;
    step();
    ack = 1'b0;
    chk("R6", "ack with one-cycle period", done, 1'b0);
  endtask

  initial begin
    step(); step(); step();
    test_reset();
    rst_ni = 1'b1;
    step();
    test_reset();
    test_basic_run();
    test_zero_write();
    test_write_on_boundary();
    test_replace();
    test_disable();
    test_reenable();
    test_zero_period();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule